// File: doc/BRIEF.md
# Scrambled NRZI Video Serializer

This block turns 10-bit parallel video words into one serial bit stream for a serial digital video link. A strobe marks the serial clock cycle in which a new word is captured. The ten bits of that word then leave one per serial clock, least significant bit first. The serial clock runs at ten times the word rate, and the strobe arrives every tenth cycle. Each bit passes through a self-synchronizing scrambler with the polynomial x^9 + x^4 + 1, and then through an NRZ-to-NRZI encoder with the polynomial x + 1. It leaves on a registered output pair, true and complement.

A bypass control skips both coding stages and sends the raw serialized bits to the line. A separate scrambler clear restarts the coding state without touching the word shifter. A lock-status input from the clock source holds the line quiet while the serial clock cannot be trusted.

Top module: `vid_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sdo_p` becomes 0 and `sdo_n` becomes 1, and the scrambler register and the NRZI level are cleared to zero.
- R2: In a cycle with `load` high, bit 0 of `word_in` is the bit processed. Bits 1 to 9 of that word are processed in the nine following cycles, in rising bit order. Each processed bit appears on the output one clock after its cycle. `word_in` is ignored in cycles with `load` low.
- R3: The scrambler register q holds past scrambled bits, with q[0] the most recent. The scrambled bit is s = b XOR q[3] XOR q[8], where b is the processed bit. The bit s, not b, is then shifted into q[0].
- R4: When coding is active, the output level equals the previous NRZI level XOR s, so a scrambled one produces a transition and a scrambled zero produces none.
- R5: With `bypass` high, the output carries the raw processed bit. The scrambler register and the NRZI level hold their values, so coding resumes seamlessly when `bypass` returns low.
- R6: In a cycle with `scr_clr` high, the scrambler register and the NRZI level are taken as zero before that cycle's bit is coded. A word loaded in that same cycle is coded from the cleared state.
- R7: With `locked` low, `sdo_p` is 0 one clock later, even when `bypass` is high. The NRZI level holds its value, and the scrambler keeps advancing on the bits that pass.
- R8: `sdo_n` is always the complement of `sdo_p`.
- R9: An output stream with `locked` high is descrambled by the inverse polynomials. That means NRZI decoding followed by the self-synchronizing descrambler, started from zero state at reset or clear. The descrambled stream reproduces the loaded words bit for bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock, ten times the word rate |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Word capture strobe, high once every ten cycles |
| word_in | input | 10 | Parallel video word |
| bypass | input | 1 | Skips scrambling and NRZI coding |
| scr_clr | input | 1 | Clears scrambler and NRZI state |
| locked | input | 1 | Clock source lock status; low mutes the line |
| sdo_p | output | 1 | Serial data, true |
| sdo_n | output | 1 | Serial data, complement |

## Verification
A scrambler clear can land in the same cycle as a word load. In that case the bit being loaded must be coded from the zeroed state rather than from the old history. The bench provokes this by raising `scr_clr` together with `load`. It judges the result two ways: it compares every output bit against its own encoder model, and it descrambles the stream with a descrambler that restarts from zero on that cycle and checks that the word comes back intact. Mute and bypass also coincide in one directed word, where the line must stay quiet.

// File: rtl/vid_serializer.sv
module vid_serializer #(
  parameter int WORD_W = 10,
  parameter int LFSR_W = 9,
  parameter int TAP    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              bypass,
  input  logic              scr_clr,
  input  logic              locked,
  output logic              sdo_p,
  output logic              sdo_n
);

  localparam int SH_W = WORD_W - 1;

  logic [SH_W-1:0]   sreg;
  logic [LFSR_W-1:0] lfsr;
  logic              nrzi;
  logic              pos_q;
  logic              neg_q;

  logic [LFSR_W-1:0] lf_eff;
  logic              nz_eff;
  logic              raw;
  logic              scr;
  logic              nz_nxt;
  logic              line;

  assign lf_eff = scr_clr ? '0 : lfsr;
  assign nz_eff = scr_clr ? 1'b0 : nrzi;
  assign raw    = load ? word_in[0] : sreg[0];
  assign scr    = raw ^ lf_eff[TAP-1] ^ lf_eff[LFSR_W-1];
  assign nz_nxt = nz_eff ^ scr;
  assign line   = !locked ? 1'b0 : (bypass ? raw : nz_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg  <= '0;
      lfsr  <= '0;
      nrzi  <= 1'b0;
      pos_q <= 1'b0;
      neg_q <= 1'b1;
    end else begin
      sreg  <= load ? word_in[WORD_W-1:1] : {1'b0, sreg[SH_W-1:1]};
      lfsr  <= bypass ? lf_eff : {lf_eff[LFSR_W-2:0], scr};
      nrzi  <= (!bypass && locked) ? nz_nxt : nz_eff;
      pos_q <= line;
      neg_q <= ~line;
    end
  end

  assign sdo_p = pos_q;
  assign sdo_n = neg_q;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sreg == $past(word_in[WORD_W-1:1]));

  // R3
  scr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !scr_clr) |=> lfsr[LFSR_W-1:1] == $past(lfsr[LFSR_W-2:0]));

  // R3
  scr_feedback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !scr_clr && !load) |=>
      lfsr[0] == ($past(sreg[0]) ^ $past(lfsr[TAP-1]) ^ $past(lfsr[LFSR_W-1])));

  // R4
  nrzi_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && locked && !scr_clr) |=> (nrzi ^ $past(nrzi)) == lfsr[0]);

  // R4
  nrzi_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && locked) |=> sdo_p == nrzi);

  // R5
  bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !scr_clr) |=> $stable(lfsr) && $stable(nrzi));

  // R6
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_clr && !bypass) |=> lfsr[LFSR_W-1:1] == '0);

  // R7
  mute_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !sdo_p && sdo_n);

  // R7
  mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !scr_clr) |=> $stable(nrzi));

  // R8
  pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_n == !sdo_p);

endmodule

// File: tb/sim_vid_serializer.sv
`timescale 1ns/1ps
module sim_vid_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [9:0] word_in = '0;
  logic       bypass = 1'b0;
  logic       scr_clr = 1'b0;
  logic       locked = 1'b1;
  logic       sdo_p, sdo_n;

  int n_chk = 0;
  int n_bad = 0;

  logic [8:0] mlf = '0;
  logic       mnz = 1'b0;
  logic [8:0] dq = '0;
  logic       yprev = 1'b0;

  localparam logic [9:0] VEC [12] = '{
    10'h000, 10'h3FF, 10'h2AA, 10'h155, 10'h001, 10'h200,
    10'h0F0, 10'h30F, 10'h123, 10'h3A5, 10'h05A, 10'h3C3};

  always #10 clk = ~clk;

  vid_serializer u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .word_in(word_in),
    .bypass(bypass), .scr_clr(scr_clr), .locked(locked),
    .sdo_p(sdo_p), .sdo_n(sdo_n));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [9:0] w, input logic byp, input logic lk,
                           input logic clr0, input logic cmp, input string tag);
    logic [9:0] rec;
    rec = '0;
    for (int i = 0; i < 10; i++) begin
      logic b, clr, s, nzn, ex, ds;
      logic [8:0] le;
      logic ne;
      b   = w[i];
      clr = clr0 && (i == 0);
      @(negedge clk);
      load    = (i == 0);
      word_in = (i == 0) ? w : ~w;
      bypass  = byp;
      locked  = lk;
      scr_clr = clr;
      le  = clr ? 9'd0 : mlf;
      ne  = clr ? 1'b0 : mnz;
      s   = b ^ le[3] ^ le[8];
      nzn = ne ^ s;
      ex  = !lk ? 1'b0 : (byp ? b : nzn);
      mlf = byp ? le : {le[7:0], s};
      mnz = (!byp && lk) ? nzn : ne;
      @(posedge clk);
      #5;
      check(tag, {15'd0, sdo_p}, {15'd0, ex});
      check("R8 complement", {15'd0, sdo_n}, {15'd0, ~ex});
      if (!byp && lk) begin
        if (clr) begin
          dq = '0;
          yprev = 1'b0;
        end
        ds = sdo_p ^ yprev;
        rec[i] = ds ^ dq[3] ^ dq[8];
        dq = {dq[7:0], ds};
        yprev = sdo_p;
      end
    end
    if (cmp) check("R9 descrambled word", {6'd0, rec}, {6'd0, w});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    load = 1'b0;
    scr_clr = 1'b0;
    @(posedge clk);
    #5;
    check("R1 reset sdo_p", {15'd0, sdo_p}, 16'd0);
    check("R1 reset sdo_n", {15'd0, sdo_n}, 16'd1);
    mlf = '0; mnz = 1'b0; dq = '0; yprev = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset sdo_p", {15'd0, sdo_p}, 16'd0);
    check("R1 reset sdo_n", {15'd0, sdo_n}, 16'd1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < 12; k++)
      send_word(VEC[k], 1'b0, 1'b1, 1'b0, 1'b1, "R2 R3 R4 serial bit");

    send_word(10'h1B7, 1'b0, 1'b1, 1'b1, 1'b1, "R6 clear with load");
    send_word(10'h2C5, 1'b1, 1'b1, 1'b0, 1'b0, "R5 bypass raw");
    send_word(10'h0E1, 1'b0, 1'b1, 1'b0, 1'b1, "R5 resume after bypass");
    send_word(10'h3A1, 1'b0, 1'b0, 1'b0, 1'b0, "R7 muted");
    send_word(10'h155, 1'b0, 1'b1, 1'b0, 1'b0, "R7 nrzi level held");
    send_word(10'h26B, 1'b0, 1'b1, 1'b0, 1'b1, "R7 resync");
    send_word(10'h3FF, 1'b1, 1'b0, 1'b0, 1'b0, "R7 mute over bypass");
    do_reset();
    send_word(10'h000, 1'b0, 1'b1, 1'b0, 1'b1, "R1 restart");
    send_word(10'h3E8, 1'b0, 1'b1, 1'b0, 1'b1, "R3 after restart");

    @(negedge clk);
    load = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule